// File: doc/BRIEF.md
# Interrupt Pin Trigger and Service Unit

This unit sits between the interrupt pins of an I/O interrupt controller and the delivery path toward the processors. Each cycle it samples the raw pin levels and applies each pin's polarity to get an effective level. It keeps one request bit per pin and a remote-acknowledge flag per table entry. From these it decides which pins need service. A serviced pin that is unmasked produces a delivery record built from its table entry.

Each pin's redirection entry is a set of plain inputs: mask, polarity, trigger kind, vector, destination, destination mode and delivery mode. Edge pins are serviced on a fresh rise of their request bit. Level pins are serviced while their remote-acknowledge flag is clear. The flag is set when a delivery is issued and cleared by a level-type end-of-interrupt (EOI) strobe whose vector matches. If the pin is still asserted after that clear, it is serviced again.

For every assertion, the unit reports whether the assertion was taken or merged into service that was already outstanding. It also publishes a map with one bit for each vector that some entry uses.

Deliveries leave on a valid/ready port. A record stays on the port unchanged until the cycle in which `out_ready` is high. A new record may replace it in that same cycle, so back-pressure holds back the whole service queue. The EOI input is a single-cycle strobe that is always accepted. It has no ready signal.

Top module: `pin_service_unit`

## Requirements
- R1: The effective level of a pin is its raw level XOR its polarity bit (1 = active low). The request bit `req[i]` equals the effective level of the previous cycle. An effective level of 0 clears the request bit.
- R2: An edge pin (`ent_trig[i]`=0) is serviced once for each 0-to-1 change of its effective level. Holding the level high produces no further delivery.
- R3: When an unmasked level pin (`ent_trig[i]`=1) is serviced, its flag `rirr[i]` is set in the cycle the record is loaded. While the flag is set, the pin is not serviced again, and the flag stays set until a level-type EOI with a matching vector arrives.
- R4: Every 0-to-1 change of a pin's effective level pulses exactly one of `took[i]` and `merged[i]` in that same cycle. The assertion is merged when the pin already has service pending (not granted this cycle), or, for a level pin, when its `rirr` flag is set.
- R5: Servicing a masked pin consumes the pending service. It issues no delivery and leaves `rirr` unchanged.
- R6: A delivery carries the pin index and that pin's destination, vector, destination mode, trigger kind and 3-bit delivery mode. `out_level` is always 1 and `out_shorthand` is always 0.
- R7: While `out_valid` is high and `out_ready` is low, every delivery field holds its value.
- R8: A level-type EOI (`eoi_level_trig`=1) clears `rirr` on every entry whose vector equals `eoi_vector`. A pin that is still asserted is then serviced again.
- R9: An edge-type EOI (`eoi_level_trig`=0) clears no `rirr` flag.
- R10: Pins waiting for service are granted in ascending index order, at most one per cycle. With `out_ready` high, they produce deliveries in consecutive cycles.
- R11: `vec_map[v]` is 1 exactly when some entry's vector equals v. It follows table changes in the same cycle.
- R12: Reset clears all request bits, all pending service, all `rirr` flags and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_raw | input | NPINS | Raw pin levels |
| ent_pol | input | NPINS | Per-pin polarity, 1 = active low |
| ent_mask | input | NPINS | Per-pin mask |
| ent_trig | input | NPINS | Per-pin trigger kind, 1 = level, 0 = edge |
| ent_vec | input | NPINS*VEC_W | Per-pin vector, pin i at bits [i*VEC_W +: VEC_W] |
| ent_dest | input | NPINS*DEST_W | Per-pin destination |
| ent_dmode | input | NPINS | Per-pin destination mode |
| ent_dlvm | input | NPINS*3 | Per-pin delivery mode |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | VEC_W | Vector being acknowledged |
| eoi_level_trig | input | 1 | 1 = level-type EOI |
| out_valid | output | 1 | Delivery record valid |
| out_ready | input | 1 | Downstream accepts the record |
| out_pin | output | PIN_W | Pin that produced the record |
| out_dest | output | DEST_W | Destination |
| out_vector | output | VEC_W | Vector |
| out_dmode | output | 1 | Destination mode |
| out_trig | output | 1 | Trigger kind |
| out_dlvm | output | 3 | Delivery mode |
| out_level | output | 1 | Always 1 |
| out_shorthand | output | 2 | Always 0 |
| took | output | NPINS | Assertion accepted for service this cycle |
| merged | output | NPINS | Assertion merged this cycle |
| req | output | NPINS | Request register |
| rirr | output | NPINS | Remote-acknowledge flags |
| vec_map | output | 2**VEC_W | Vectors in use |

## Verification
The bench builds the unit with four pins, 8-bit vectors and 8-bit destinations. With four pins it can give one pin edge triggering and three pins level triggering. Two of the level pins share a vector, so a single EOI has to clear two flags, and the ascending grant order is visible when two pins rise together. An 8-bit vector makes the map a full 256 bits, so set and clear checks at arbitrary codes are possible, including when an entry's vector changes.

// File: rtl/psu_pkg.sv
package psu_pkg;
  typedef enum logic {TRIG_EDGE = 1'b0, TRIG_LEVEL = 1'b1} trig_e;
  localparam int DLVM_W  = 3;
  localparam int SHORT_W = 2;
endpackage

// File: rtl/psu_pin_slice.sv
module psu_pin_slice
  import psu_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw,
  input  logic             pol,
  input  logic             trig,
  input  logic             mask,
  input  logic [VEC_W-1:0] vec,
  input  logic             eoi_valid,
  input  logic [VEC_W-1:0] eoi_vector,
  input  logic             eoi_level_trig,
  input  logic             grant,
  output logic             pend,
  output logic             req,
  output logic             rirr,
  output logic             took,
  output logic             merged
);
  logic eff, rise, is_lvl, set_p, eoi_hit;

  always_comb begin
    eff     = raw ^ pol;
    rise    = eff & ~req;
    is_lvl  = (trig_e'(trig) == TRIG_LEVEL);
    eoi_hit = eoi_valid & eoi_level_trig & (eoi_vector == vec);
    if (is_lvl) begin
      // level pins wait on the remote flag and on any outstanding service
      set_p  = eff & ~rirr & ~pend;
      merged = rise & (rirr | pend);
    end else begin
      set_p  = rise;
      merged = rise & pend & ~grant;
    end
    took = rise & ~merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req  <= 1'b0;
      pend <= 1'b0;
      rirr <= 1'b0;
    end else begin
      req  <= eff;
      pend <= (pend & ~grant) | set_p;
      if (grant && is_lvl && !mask) rirr <= 1'b1;
      else if (eoi_hit)             rirr <= 1'b0;
    end
  end
endmodule

// File: rtl/psu_pick.sv
module psu_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  pending,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot
);
  always_comb begin
    any    = 1'b0;
    idx    = '0;
    onehot = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pending[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
    if (any) onehot[idx] = 1'b1;
  end
endmodule

// File: rtl/psu_vecmap.sv
module psu_vecmap #(
  parameter int N     = 4,
  parameter int VEC_W = 8,
  localparam int MAP_N = 1 << VEC_W
) (
  input  logic [N*VEC_W-1:0] vecs,
  output logic [MAP_N-1:0]   map
);
  always_comb begin
    map = '0;
    for (int i = 0; i < N; i++) map[vecs[i*VEC_W +: VEC_W]] = 1'b1;
  end
endmodule

// File: rtl/pin_service_unit.sv
module pin_service_unit
  import psu_pkg::*;
#(
  parameter int NPINS  = 4,
  parameter int VEC_W  = 8,
  parameter int DEST_W = 8,
  localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1,
  localparam int MAP_N = 1 << VEC_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPINS-1:0]          pin_raw,
  input  logic [NPINS-1:0]          ent_pol,
  input  logic [NPINS-1:0]          ent_mask,
  input  logic [NPINS-1:0]          ent_trig,
  input  logic [NPINS*VEC_W-1:0]    ent_vec,
  input  logic [NPINS*DEST_W-1:0]   ent_dest,
  input  logic [NPINS-1:0]          ent_dmode,
  input  logic [NPINS*DLVM_W-1:0]   ent_dlvm,
  input  logic                      eoi_valid,
  input  logic [VEC_W-1:0]          eoi_vector,
  input  logic                      eoi_level_trig,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [PIN_W-1:0]          out_pin,
  output logic [DEST_W-1:0]         out_dest,
  output logic [VEC_W-1:0]          out_vector,
  output logic                      out_dmode,
  output logic                      out_trig,
  output logic [DLVM_W-1:0]         out_dlvm,
  output logic                      out_level,
  output logic [SHORT_W-1:0]        out_shorthand,
  output logic [NPINS-1:0]          took,
  output logic [NPINS-1:0]          merged,
  output logic [NPINS-1:0]          req,
  output logic [NPINS-1:0]          rirr,
  output logic [MAP_N-1:0]          vec_map
);
  logic [NPINS-1:0] pend, gnt_oh, grant;
  logic             any_pend, fire;
  logic [PIN_W-1:0] sel;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    psu_pin_slice #(.VEC_W(VEC_W)) u_slice (
      .clk            (clk),
      .rst_n          (rst_n),
      .raw            (pin_raw[i]),
      .pol            (ent_pol[i]),
      .trig           (ent_trig[i]),
      .mask           (ent_mask[i]),
      .vec            (ent_vec[i*VEC_W +: VEC_W]),
      .eoi_valid      (eoi_valid),
      .eoi_vector     (eoi_vector),
      .eoi_level_trig (eoi_level_trig),
      .grant          (grant[i]),
      .pend           (pend[i]),
      .req            (req[i]),
      .rirr           (rirr[i]),
      .took           (took[i]),
      .merged         (merged[i])
    );
  end

  psu_pick #(.N(NPINS)) u_pick (
    .pending (pend),
    .any     (any_pend),
    .idx     (sel),
    .onehot  (gnt_oh)
  );

  psu_vecmap #(.N(NPINS), .VEC_W(VEC_W)) u_map (
    .vecs (ent_vec),
    .map  (vec_map)
  );

  // a new grant may be taken whenever the output slot is empty or draining
  assign fire  = any_pend & (~out_valid | out_ready);
  assign grant = fire ? gnt_oh : '0;

  assign out_level     = 1'b1;
  assign out_shorthand = '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_pin    <= '0;
      out_dest   <= '0;
      out_vector <= '0;
      out_dmode  <= 1'b0;
      out_trig   <= 1'b0;
      out_dlvm   <= '0;
    end else if (fire && !ent_mask[sel]) begin
      out_valid  <= 1'b1;
      out_pin    <= sel;
      out_dest   <= ent_dest[sel*DEST_W +: DEST_W];
      out_vector <= ent_vec[sel*VEC_W +: VEC_W];
      out_dmode  <= ent_dmode[sel];
      out_trig   <= ent_trig[sel];
      out_dlvm   <= ent_dlvm[sel*DLVM_W +: DLVM_W];
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/psu_checker.sv
module psu_checker #(
  parameter int NPINS = 4,
  parameter int VEC_W = 8,
  localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] pin_raw,
  input logic [NPINS-1:0] ent_pol,
  input logic [NPINS-1:0] ent_mask,
  input logic             eoi_valid,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PIN_W-1:0] out_pin,
  input logic [VEC_W-1:0] out_vector,
  input logic [NPINS-1:0] req,
  input logic [NPINS-1:0] rirr
);
  logic             seen;
  logic [NPINS-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen   <= 1'b0;
      mask_q <= '0;
    end else begin
      seen   <= 1'b1;
      mask_q <= ent_mask;
    end
  end

  AST_REQ_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (req == $past(pin_raw ^ ent_pol))); // R1

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pin) && $stable(out_vector))); // R7

  AST_MASK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> !mask_q[out_pin]); // R5

  for (genvar i = 0; i < NPINS; i++) begin : g_hold
    AST_RIRR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rirr[i] && !eoi_valid) |=> rirr[i]); // R3
  end
endmodule

bind pin_service_unit psu_checker #(.NPINS(NPINS), .VEC_W(VEC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pin_raw    (pin_raw),
  .ent_pol    (ent_pol),
  .ent_mask   (ent_mask),
  .eoi_valid  (eoi_valid),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_pin    (out_pin),
  .out_vector (out_vector),
  .req        (req),
  .rirr       (rirr)
);

// File: tb/pin_service_unit_test.sv
`timescale 1ns/1ps
module pin_service_unit_test;
  localparam int NP = 4;
  localparam int VW = 8;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] pin_raw = '0, ent_pol = '0, ent_mask = '0;
  logic [NP-1:0] ent_trig = 4'b1110;
  logic [NP*VW-1:0] ent_vec = {8'h40, 8'h40, 8'h31, 8'h30};
  logic [NP*DW-1:0] ent_dest = {8'h13, 8'h12, 8'h11, 8'h10};
  logic [NP-1:0] ent_dmode = 4'b1010;
  logic [NP*3-1:0] ent_dlvm = {3'd3, 3'd2, 3'd1, 3'd0};
  logic eoi_valid = 1'b0, eoi_level_trig = 1'b0, out_ready = 1'b1;
  logic [VW-1:0] eoi_vector = '0;
  logic out_valid, out_dmode, out_trig, out_level;
  logic [1:0] out_pin, out_shorthand;
  logic [DW-1:0] out_dest;
  logic [VW-1:0] out_vector;
  logic [2:0] out_dlvm;
  logic [NP-1:0] took, merged, req, rirr;
  logic [255:0] vec_map;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pin_service_unit #(.NPINS(NP), .VEC_W(VW), .DEST_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .ent_pol(ent_pol),
    .ent_mask(ent_mask), .ent_trig(ent_trig), .ent_vec(ent_vec),
    .ent_dest(ent_dest), .ent_dmode(ent_dmode), .ent_dlvm(ent_dlvm),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .eoi_level_trig(eoi_level_trig),
    .out_valid(out_valid), .out_ready(out_ready), .out_pin(out_pin),
    .out_dest(out_dest), .out_vector(out_vector), .out_dmode(out_dmode),
    .out_trig(out_trig), .out_dlvm(out_dlvm), .out_level(out_level),
    .out_shorthand(out_shorthand), .took(took), .merged(merged), .req(req),
    .rirr(rirr), .vec_map(vec_map)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [3:0] raw, pol, msk;
    logic       ev;
    logic [7:0] evec;
    logic       el, rdy;
    logic [3:0] xreq, xtook, xmrg;
    logic       xdv;
    logic [1:0] xpin;
    logic [3:0] xrirr;
  } row_t;

  // pin0 edge vec 30, pin1 level vec 31, pins 2/3 level vec 40
  localparam row_t TBL [21] = '{
    '{4'h1,4'h0,4'h0,1'b0,8'h00,1'b0,1'b1, 4'h0,4'h1,4'h0,1'b0,2'd0,4'h0}, // R2 edge rise taken
    '{4'h1,4'h0,4'h0,1'b0,8'h00,1'b0,1'b1, 4'h1,4'h0,4'h0,1'b0,2'd0,4'h0}, // R2 held high
    '{4'h0,4'h0,4'h0,1'b0,8'h00,1'b0,1'b1, 4'h1,4'h0,4'h0,1'b1,2'd0,4'h0}, // R2 one delivery
    '{4'h2,4'h0,4'h0,1'b0,8'h00,1'b0,1'b1, 4'h0,4'h2,4'h0,1'b0,2'd0,4'h0}, // R3 level rise
    '{4'h2,4'h0,4'h0,1'b0,8'h00,1'b0,1'b1, 4'h2,4'h0,4'h0,1'b0,2'd0,4'h0},
    '{4'h0,4'h0,4'h0,1'b0,8'h00,1'b0,1'b1, 4'h2,4'h0,4'h0,1'b1,2'd1,4'h2}, // R3 flag set
    '{4'h2,4'h0,4'h0,1'b0,8'h00,1'b0,1'b1, 4'h0,4'h0,4'h2,1'b0,2'd0,4'h2}, // R4 merged by flag
    '{4'h2,4'h0,4'h0,1'b1,8'h31,1'b1,1'b1, 4'h2,4'h0,4'h0,1'b0,2'd0,4'h2}, // R8 level EOI
    '{4'h2,4'h0,4'h0,1'b0,8'h00,1'b0,1'b1, 4'h2,4'h0,4'h0,1'b0,2'd0,4'h0}, // R8 flag cleared
    '{4'h2,4'h0,4'h0,1'b0,8'h00,1'b0,1'b1, 4'h2,4'h0,4'h0,1'b0,2'd0,4'h0},
    '{4'h2,4'h0,4'h0,1'b0,8'h00,1'b0,1'b0, 4'h2,4'h0,4'h0,1'b1,2'd1,4'h2}, // R8 redelivered, R7 stall
    '{4'h2,4'h0,4'h0,1'b0,8'h00,1'b0,1'b1, 4'h2,4'h0,4'h0,1'b1,2'd1,4'h2}, // R7 held
    '{4'h0,4'h8,4'h0,1'b0,8'h00,1'b0,1'b1, 4'h2,4'h8,4'h0,1'b0,2'd0,4'h2}, // R1 active-low rise
    '{4'h0,4'h8,4'h8,1'b0,8'h00,1'b0,1'b1, 4'h8,4'h0,4'h0,1'b0,2'd0,4'h2}, // R5 masked grant
    '{4'h0,4'h8,4'h8,1'b0,8'h00,1'b0,1'b1, 4'h8,4'h0,4'h0,1'b0,2'd0,4'h2}, // R5 nothing out
    '{4'h0,4'h8,4'h8,1'b0,8'h00,1'b0,1'b1, 4'h8,4'h0,4'h0,1'b0,2'd0,4'h2}, // R5
    '{4'h0,4'h0,4'h0,1'b0,8'h00,1'b0,1'b1, 4'h8,4'h0,4'h0,1'b0,2'd0,4'h2}, // R5 flag untouched
    '{4'h0,4'h0,4'h0,1'b1,8'h31,1'b0,1'b1, 4'h0,4'h0,4'h0,1'b0,2'd0,4'h2}, // R9 edge EOI
    '{4'h0,4'h0,4'h0,1'b0,8'h00,1'b0,1'b1, 4'h0,4'h0,4'h0,1'b0,2'd0,4'h2}, // R9 flag kept
    '{4'h0,4'h0,4'h0,1'b1,8'h31,1'b1,1'b1, 4'h0,4'h0,4'h0,1'b0,2'd0,4'h2}, // R8
    '{4'h0,4'h0,4'h0,1'b0,8'h00,1'b0,1'b1, 4'h0,4'h0,4'h0,1'b0,2'd0,4'h0}  // R8 cleared
  };

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    int cyc [2];
    logic [1:0] pins [2];
    repeat (3) @(negedge clk);
    #3;
    // R12 reset state
    chk(req == 4'h0 && rirr == 4'h0 && !out_valid, "R12 reset state", {req, rirr, 3'b0, out_valid}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    foreach (TBL[k]) begin
      @(negedge clk);
      pin_raw = TBL[k].raw; ent_pol = TBL[k].pol; ent_mask = TBL[k].msk;
      eoi_valid = TBL[k].ev; eoi_vector = TBL[k].evec; eoi_level_trig = TBL[k].el;
      out_ready = TBL[k].rdy;
      #3;
      chk(req == TBL[k].xreq, "R1 req", req, TBL[k].xreq);
      chk(took == TBL[k].xtook, "R4 took", took, TBL[k].xtook);
      chk(merged == TBL[k].xmrg, "R4 merged", merged, TBL[k].xmrg);
      chk(out_valid == TBL[k].xdv, "R2 out_valid", out_valid, TBL[k].xdv);
      if (TBL[k].xdv) chk(out_pin == TBL[k].xpin, "R6 out_pin", out_pin, TBL[k].xpin);
      chk(rirr == TBL[k].xrirr, "R3 rirr", rirr, TBL[k].xrirr);
    end

    // R10 ascending order, R6 fields: pins 2 and 3 rise together
    @(negedge clk);
    eoi_valid = 1'b0; out_ready = 1'b1; pin_raw = 4'b1100;
    n = 0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      #3;
      if (out_valid) begin
        if (n < 2) begin
          cyc[n] = c;
          pins[n] = out_pin;
        end
        n++;
        chk(out_vector == 8'h40, "R6 vector", out_vector, 8'h40);
        chk(out_dest == 8'h10 + out_pin, "R6 dest", out_dest, 8'h10 + out_pin);
        chk(out_dmode == out_pin[0] && out_trig == 1'b1, "R6 mode bits", {out_dmode, out_trig}, {out_pin[0], 1'b1});
        chk(out_dlvm == 3'(out_pin), "R6 delivery mode", out_dlvm, out_pin);
        chk(out_level == 1'b1 && out_shorthand == 2'b00, "R6 level/shorthand", {out_level, out_shorthand}, 3'b100);
      end
    end
    chk(n == 2, "R10 delivery count", n, 2);
    if (n == 2) begin
      chk(pins[0] == 2'd2 && pins[1] == 2'd3, "R10 order", {pins[0], pins[1]}, 4'b1011);
      chk(cyc[1] == cyc[0] + 1, "R10 back-to-back", cyc[1], cyc[0] + 1);
    end
    chk(rirr == 4'b1100, "R3 both flags", rirr, 4'b1100);

    // R8 one EOI clears both entries sharing vector 40
    @(negedge clk);
    pin_raw = 4'b0000;
    @(negedge clk);
    eoi_valid = 1'b1; eoi_vector = 8'h40; eoi_level_trig = 1'b1;
    @(negedge clk);
    eoi_valid = 1'b0;
    #3;
    chk(rirr == 4'b0000, "R8 shared vector", rirr, 4'b0000);
    chk(!out_valid, "R8 no redelivery when idle", out_valid, 0);

    // R11 vector map
    chk(vec_map[8'h30] && vec_map[8'h31] && vec_map[8'h40], "R11 map bits", vec_map[8'h40], 1);
    chk($countones(vec_map) == 3, "R11 map count", $countones(vec_map), 3);
    ent_vec[7:0] = 8'h55;
    #1;
    chk(vec_map[8'h55] && !vec_map[8'h30], "R11 map follows table", {vec_map[8'h55], vec_map[8'h30]}, 2'b10);

    // R12 reset mid-run
    @(negedge clk);
    pin_raw = 4'b0010;
    repeat (3) @(negedge clk);
    #3;
    chk(rirr == 4'b0010, "R3 flag before reset", rirr, 4'b0010);
    rst_n = 1'b0;
    #1;
    chk(req == 4'h0 && rirr == 4'h0 && !out_valid, "R12 reset clears", {req, rirr}, 0);
    @(negedge clk);
    pin_raw = 4'b0000;
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    summary();
    $finish;
  end
endmodule